// File: doc/BRIEF.md
# Video Transmitter I2C Boot Sequencer

This block programs an external video transmitter over I2C as soon as reset is released. It holds the rest of the display pipeline in reset while it works. The list of writes is fixed in logic. The sequencer walks through it one pair at a time. Each pair is a register address and a value, sent as a single write to a 7-bit slave address set by a parameter. When the list is finished, the block raises a done flag and releases the pipeline's reset.

The block drives SCL and SDA in open-drain style. A tristate-enable of 1 releases the line. A tristate-enable of 0 pulls the line low through a data output that is always 0. The block samples the SDA input in each acknowledge slot. If the slave does not acknowledge, the block stops the transfer and repeats the same pair a bounded number of times. If the pair still fails, it records a sticky error and moves on, so the display always comes out of reset.

A parameter removes the function entirely for analog-video builds. In that case the bus outputs stay at 0 and the pipeline is released straight after reset.

Top module: `vidtx_i2c_boot`

## Requirements
- R1: While reset is asserted and just after it, scl_t and sda_t are 1 (lines released), and cfg_done, cfg_err and disp_rst_n are 0.
- R2: The block sends the writes in this order, one transaction per pair (register, value): (0x49, 0xC0), (0x21, 0x09), (0x33, 0x08), (0x34, 0x16), (0x36, 0x60). It sends no other transactions apart from the retries of R6.
- R3: Each transaction has these parts, in order:
  - a START (SDA falls while SCL is high);
  - the address byte {SLAVE_ADDR, 0}, which is 0xEC by default;
  - the register byte;
  - the value byte;
  - a STOP (SDA rises while SCL is high).
  Each byte is sent MSB first and is followed by a ninth acknowledge clock with SDA released.
- R4: SDA changes only while SCL is low, except at the START and STOP edges.
- R5: Within a byte, consecutive rising edges of SCL are exactly 4*QTR_CYCLES clocks apart.
- R6: If SDA reads 1 in an acknowledge slot, the block ends the transaction with a STOP right after that slot and sends no further bytes. It then repeats the same pair, up to MAX_RETRY extra attempts.
- R7: If a pair is still not acknowledged after all its attempts, cfg_err goes to 1 and stays at 1 until reset. The block then carries on with the next pair.
- R8: cfg_done rises exactly 2*QTR_CYCLES-1 clocks after SDA rises in the final STOP. cfg_done stays high afterwards, with both lines released and no further bus activity. disp_rst_n is 0 before done and 1 after done.
- R9: With ENABLE=0, scl_o, scl_t, sda_o, sda_t and cfg_err stay at 0, and cfg_done and disp_rst_n are 1 from the first clock after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | SCL drive value (always 0) |
| scl_t | output | 1 | SCL tristate enable, 1 = released |
| sda_o | output | 1 | SDA drive value (always 0) |
| sda_t | output | 1 | SDA tristate enable, 1 = released |
| cfg_done | output | 1 | Script finished |
| cfg_err | output | 1 | Sticky flag: a pair exhausted its retries |
| disp_rst_n | output | 1 | Active-low reset for the display pipeline |

## Verification
A slave model on the bench decodes every START, bit, acknowledge and STOP, and logs each transaction it sees. The bench runs five acknowledge patterns:
- All writes acknowledged. This shows the plain script order and the byte contents.
- A single refused address byte. This shows that the block stops early and repeats once.
- A value byte refused on every attempt. This shows that the retry limit is honoured and that the error flag is set before the block moves on.
- A register byte refused on every attempt of the last pair. This shows that done and the reset release still follow.
- Two refusals followed by success. This shows that the retry count resets per pair and that success clears the fault.

The bench rebuilds the expected transaction list in each case from the retry rule, and compares bit timing and the done-to-STOP distance against the divider value. A second instance built with the function disabled checks the tied-off outputs.

// File: rtl/vidtx_boot_pkg.sv
package vidtx_boot_pkg;

  localparam int SCRIPT_LEN = 5;

  typedef enum logic [1:0] {SEG_IDLE, SEG_START, SEG_BIT, SEG_STOP} seg_t;
  typedef enum logic [1:0] {ST_START, ST_BITS, ST_STOP, ST_DONE} st_t;

  // register address of script entry i
  function automatic logic [7:0] script_reg(input int i);
    case (i)
      0:       return 8'h49;
      1:       return 8'h21;
      2:       return 8'h33;
      3:       return 8'h34;
      default: return 8'h36;
    endcase
  endfunction

  // value written by script entry i
  function automatic logic [7:0] script_val(input int i);
    case (i)
      0:       return 8'hC0;
      1:       return 8'h09;
      2:       return 8'h08;
      3:       return 8'h16;
      default: return 8'h60;
    endcase
  endfunction

  function automatic logic [7:0] addr_wr_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  // {scl, sda} release levels for a segment and quarter phase
  function automatic logic [1:0] line_levels(input seg_t s, input logic [1:0] q,
                                             input logic b);
    case (s)
      SEG_START: return (q == 2'd3) ? 2'b00 : (q == 2'd2) ? 2'b10 : 2'b11;
      SEG_BIT:   return {(q == 2'd1) || (q == 2'd2), b};
      SEG_STOP:  return (q == 2'd0) ? 2'b00 : (q == 2'd1) ? 2'b10 : 2'b11;
      default:   return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QTR_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  // R5: quarter-period counter never passes its limit
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < QTR_CYCLES);

endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv
  import vidtx_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seg_t       seg,
  input  logic [1:0] qph,
  input  logic       bitval,
  output logic       scl_t,
  output logic       sda_t
);
  logic [1:0] lv;
  logic       cond_q;

  assign lv = line_levels(seg, qph, bitval);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_t  <= 1'b1;
      sda_t  <= 1'b1;
      cond_q <= 1'b1;
    end else begin
      scl_t  <= lv[1];
      sda_t  <= lv[0];
      cond_q <= (seg != SEG_BIT);
    end
  end

  // R4: an SDA edge under high SCL only belongs to a START or STOP
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_t && $past(scl_t) && (sda_t != $past(sda_t))) |-> cond_q);

endmodule

// File: rtl/vidtx_i2c_boot.sv
module vidtx_i2c_boot
  import vidtx_boot_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h76,
  parameter int         QTR_CYCLES = 250,
  parameter int         MAX_RETRY  = 2,
  parameter int         ENABLE     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_t,
  output logic sda_o,
  output logic sda_t,
  output logic cfg_done,
  output logic cfg_err,
  output logic disp_rst_n
);
  localparam int PW = (SCRIPT_LEN > 1) ? $clog2(SCRIPT_LEN) : 1;
  localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  generate
    if (ENABLE != 0) begin : g_on
      st_t           st;
      logic [PW-1:0] pair_idx;
      logic [1:0]    byte_idx;
      logic [3:0]    bit_idx;
      logic [1:0]    qph;
      logic [RW-1:0] retry_cnt;
      logic          nacked, done_q, err_q;
      logic          tick, seg_end, ack_slot_end, stop_end;
      logic          pair_last, retry_left, bitval;
      logic [7:0]    cur_byte;
      seg_t          seg;
      logic          run;

      assign run          = (st != ST_DONE);
      assign seg_end      = tick && (qph == 2'd3);
      assign ack_slot_end = tick && (st == ST_BITS) && (bit_idx == 4'd8) && (qph == 2'd2);
      assign stop_end     = seg_end && (st == ST_STOP);
      assign pair_last    = (pair_idx == PW'(SCRIPT_LEN - 1));
      assign retry_left   = (int'(retry_cnt) < MAX_RETRY);

      i2c_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
      );

      always_comb begin
        case (byte_idx)
          2'd0:    cur_byte = addr_wr_byte(SLAVE_ADDR);
          2'd1:    cur_byte = script_reg(int'(pair_idx));
          default: cur_byte = script_val(int'(pair_idx));
        endcase
        bitval = (bit_idx == 4'd8) ? 1'b1 : cur_byte[3'd7 - bit_idx[2:0]];
        case (st)
          ST_START: seg = SEG_START;
          ST_BITS:  seg = SEG_BIT;
          ST_STOP:  seg = SEG_STOP;
          default:  seg = SEG_IDLE;
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st        <= ST_START;
          pair_idx  <= '0;
          byte_idx  <= '0;
          bit_idx   <= '0;
          qph       <= '0;
          retry_cnt <= '0;
          nacked    <= 1'b0;
          done_q    <= 1'b0;
          err_q     <= 1'b0;
        end else begin
          if (ack_slot_end) nacked <= sda_i;
          if (tick) qph <= qph + 2'd1;
          if (seg_end) begin
            case (st)
              ST_START: begin
                st       <= ST_BITS;
                byte_idx <= '0;
                bit_idx  <= '0;
                nacked   <= 1'b0;
              end
              ST_BITS: begin
                if (bit_idx == 4'd8) begin
                  if (nacked || byte_idx == 2'd2) st <= ST_STOP;
                  else begin
                    byte_idx <= byte_idx + 2'd1;
                    bit_idx  <= '0;
                  end
                end else begin
                  bit_idx <= bit_idx + 4'd1;
                end
              end
              ST_STOP: begin
                if (nacked && retry_left) begin
                  retry_cnt <= retry_cnt + RW'(1);
                  st        <= ST_START;
                end else begin
                  if (nacked) err_q <= 1'b1;
                  retry_cnt <= '0;
                  if (pair_last) begin
                    st     <= ST_DONE;
                    done_q <= 1'b1;
                  end else begin
                    pair_idx <= pair_idx + PW'(1);
                    st       <= ST_START;
                  end
                end
              end
              default: ;
            endcase
          end
        end
      end

      i2c_line_drv u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .seg   (seg),
        .qph   (qph),
        .bitval(bitval),
        .scl_t (scl_t),
        .sda_t (sda_t)
      );

      assign scl_o      = 1'b0;
      assign sda_o      = 1'b0;
      assign cfg_done   = done_q;
      assign cfg_err    = err_q;
      assign disp_rst_n = done_q;

      // R8: done only rises right after a STOP completes
      a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(stop_end));

      // R8: once done, stay done with both lines released
      a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && scl_t && sda_t));

      // R7: error flag is sticky
      a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

      // R6: retry counter bounded
      a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(retry_cnt) <= MAX_RETRY);

      // R6: a refused byte leads straight to STOP
      a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && st == ST_BITS && bit_idx == 4'd8 && nacked) |=> (st == ST_STOP));

      // R3: SDA is released during the acknowledge clock
      a_r3_ack_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BITS && bit_idx == 4'd8 && qph == 2'd2) |-> sda_t);

    end else begin : g_off
      logic up_q;

      always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
      end

      assign scl_o      = 1'b0;
      assign scl_t      = 1'b0;
      assign sda_o      = 1'b0;
      assign sda_t      = 1'b0;
      assign cfg_err    = 1'b0;
      assign cfg_done   = up_q;
      assign disp_rst_n = up_q;

      // R9: disabled build keeps the bus outputs low
      a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_t || sda_t || cfg_err));
    end
  endgenerate

endmodule

// File: tb/tb_vidtx_i2c_boot.sv
`timescale 1ns/1ps
module tb_vidtx_i2c_boot;
  localparam int Q  = 2;
  localparam int MR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_o, scl_t, sda_o, sda_t, cfg_done, cfg_err, disp_rst_n;
  logic f_scl_o, f_scl_t, f_sda_o, f_sda_t, f_done, f_err, f_rst_n;
  logic slave_low = 1'b0;
  wire  scl_line = scl_t ? 1'b1 : scl_o;
  wire  sda_line = (sda_t ? 1'b1 : sda_o) & ~slave_low;

  vidtx_i2c_boot #(.QTR_CYCLES(Q), .MAX_RETRY(MR)) dut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_line),
    .scl_o(scl_o), .scl_t(scl_t), .sda_o(sda_o), .sda_t(sda_t),
    .cfg_done(cfg_done), .cfg_err(cfg_err), .disp_rst_n(disp_rst_n));

  vidtx_i2c_boot #(.QTR_CYCLES(Q), .MAX_RETRY(MR), .ENABLE(0)) dut_off (
    .clk(clk), .rst_n(rst_n), .sda_i(1'b1),
    .scl_o(f_scl_o), .scl_t(f_scl_t), .sda_o(f_sda_o), .sda_t(f_sda_t),
    .cfg_done(f_done), .cfg_err(f_err), .disp_rst_n(f_rst_n));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model and log
  logic [31:0] nack_mask = '0;
  int          nack_byte = 0;
  int          log_n [0:31];
  logic [7:0]  log_b [0:31][0:2];
  int          n_log = 0;
  logic [7:0]  cur_b [0:2];
  int          bitcnt, nb, txn, last_rise, last_stop_cyc;
  logic [7:0]  shreg;
  logic        p_scl, p_sda;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitcnt = 0; nb = 0; txn = 0; shreg = '0; slave_low = 1'b0;
      p_scl = 1'b1; p_sda = 1'b1; last_rise = 0;
    end else begin
      if (scl_line && p_scl && p_sda && !sda_line) begin
        bitcnt = 0; nb = 0;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        if (n_log < 32) begin
          log_n[n_log] = nb;
          for (int k = 0; k < 3; k++) log_b[n_log][k] = cur_b[k];
          n_log++;
        end
        txn++;
        last_stop_cyc = cyc;
      end else if (scl_line && !p_scl) begin
        if (bitcnt >= 1) chk((cyc - last_rise) == 4*Q, "R5 bit period", cyc - last_rise, 4*Q);
        last_rise = cyc;
        if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
        bitcnt++;
      end else if (!scl_line && p_scl) begin
        if (bitcnt == 8) begin
          if (nb < 3) cur_b[nb] = shreg;
          slave_low = !(txn < 32 && nack_mask[txn] && nb == nack_byte);
          nb++;
        end else if (bitcnt == 9) begin
          slave_low = 1'b0;
          bitcnt = 0;
        end
      end
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  // expected transaction list from the retry rule
  int         exp_n [0:31];
  logic [7:0] exp_b [0:31][0:2];
  int         exp_cnt;
  bit         exp_err;

  function automatic logic [7:0] reg_of(input int p);
    case (p) 0: return 8'h49; 1: return 8'h21; 2: return 8'h33; 3: return 8'h34; default: return 8'h36; endcase
  endfunction
  function automatic logic [7:0] val_of(input int p);
    case (p) 0: return 8'hC0; 1: return 8'h09; 2: return 8'h08; 3: return 8'h16; default: return 8'h60; endcase
  endfunction

  task automatic build_expected(input logic [31:0] mask, input int nbyte);
    int t;
    t = 0; exp_cnt = 0; exp_err = 0;
    for (int p = 0; p < 5; p++) begin
      bit ok_p;
      ok_p = 0;
      for (int a = 0; a <= MR && !ok_p; a++) begin
        bit nk;
        nk = mask[t];
        exp_n[exp_cnt]    = nk ? nbyte + 1 : 3;
        exp_b[exp_cnt][0] = 8'hEC;
        exp_b[exp_cnt][1] = reg_of(p);
        exp_b[exp_cnt][2] = val_of(p);
        exp_cnt++; t++;
        if (!nk) ok_p = 1;
        else if (a == MR) exp_err = 1;
      end
    end
  endtask

  task automatic run_case(input logic [31:0] mask, input int nbyte);
    int wd, fin_log;
    nack_mask = mask; nack_byte = nbyte;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    n_log = 0;
    build_expected(mask, nbyte);
    // R1 reset state
    chk(scl_t == 1'b1, "R1 scl_t", int'(scl_t), 1);
    chk(sda_t == 1'b1, "R1 sda_t", int'(sda_t), 1);
    chk(cfg_done == 1'b0 && cfg_err == 1'b0, "R1 done/err", int'({cfg_done, cfg_err}), 0);
    chk(disp_rst_n == 1'b0, "R1 disp_rst_n", int'(disp_rst_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 disabled build
    chk({f_scl_o, f_scl_t, f_sda_o, f_sda_t, f_err} == 5'b0, "R9 off outputs",
        int'({f_scl_o, f_scl_t, f_sda_o, f_sda_t, f_err}), 0);
    chk(f_done && f_rst_n, "R9 off done", int'({f_done, f_rst_n}), 3);
    wd = 0;
    while (!cfg_done && wd < 20000) begin
      @(negedge clk);
      wd++;
      if (wd == 40) chk(disp_rst_n == 1'b0, "R8 reset held", int'(disp_rst_n), 0);
    end
    chk(wd < 20000, "R8 watchdog", wd, 20000);
    chk((cyc - last_stop_cyc) == 2*Q - 1, "R8 done delay", cyc - last_stop_cyc, 2*Q - 1);
    fin_log = n_log;
    repeat (12*Q) @(negedge clk);
    chk(n_log == fin_log, "R8 bus quiet", n_log, fin_log);
    chk(cfg_done && disp_rst_n && scl_t && sda_t, "R8 released",
        int'({cfg_done, disp_rst_n, scl_t, sda_t}), 15);
    chk(cfg_err == exp_err, "R7 error flag", int'(cfg_err), int'(exp_err));
    chk(n_log == exp_cnt, "R6 transaction count", n_log, exp_cnt);
    for (int i = 0; i < exp_cnt && i < n_log; i++) begin
      chk(log_n[i] == exp_n[i], "R6 bytes per transaction", log_n[i], exp_n[i]);
      for (int k = 0; k < exp_n[i]; k++)
        chk(log_b[i][k] == exp_b[i][k], k == 0 ? "R3 address byte" : "R2 script byte",
            int'(log_b[i][k]), int'(exp_b[i][k]));
    end
  endtask

  initial begin
    run_case(32'h0, 0);                                 // all acknowledged
    run_case(32'h4, 0);                                 // one refused address
    run_case(32'hE, 2);                                 // value refused on every try
    run_case(32'h70, 1);                                // last pair exhausts retries
    run_case(32'h3, 1);                                 // two refusals then success
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule